// File: doc/BRIEF.md
# Sixteen-Core Shared Lookup Memory Write Fabric

This block holds one small lookup memory per core and lets every core write into the memories of the others. Each core presents a write request: a target mask with one bit per core memory, a word address, a data word and a mode bit. A mask with several bits set broadcasts one write to several memories on the same clock. The fabric gathers, for each target memory, every request aimed at it on that clock. It bitwise-ORs their addresses and their data, then performs one merged write. Requests aimed at different memories never touch each other. Each memory has a sticky flag that records a write from a foreign core. The owning core clears it.

The mode bit picks between two kinds of issue. In the immediate mode the write lands at the clock edge on which it is presented. In the slot-gated mode the write waits for the core's own turn of a free-running slot counter that visits every core index in rotation. Writers that all use this mode therefore never meet on the same clock. Each core port has a small gate machine. In `GATE_IDLE` it issues an immediate request at once, and it also issues a slot-gated request at once if the slot already matches. A slot-gated request presented off-slot takes the IDLE-to-HOLD transition: the gate captures the request and enters `GATE_HOLD` with `busy` high. The HOLD-to-IDLE transition fires on the edge where the slot equals the core index. That edge performs the captured write.

Each core reads its own memory through an asynchronous read port. That port is also how the effect of every write is observed.

Top module: `wfab_top`

## Requirements
- R1: After reset every `evt_flag` bit is 0, every `busy` bit is 0 and `slot_now` is 0.
- R2: `slot_now` advances by one on every clock edge after reset and wraps from NCORE-1 to 0.
- R3: An immediate-mode request (`req_mode` bit = 0) from an idle port writes its data to its address in each target memory at the clock edge where it is presented.
- R4: A request whose mask has several bits set writes the same address and data into every selected memory on that edge. The bit position in the mask equals the target core index.
- R5: When several sources write the same target memory on one edge, the target receives a single write whose address is the OR of their addresses and whose data is the OR of their data.
- R6: Writes from different sources to different target memories on the same edge are each performed unchanged, whatever their addresses.
- R7: A slot-gated request (`req_mode` bit = 1) presented while `slot_now` differs from the source index is captured. `busy` is then high from the next edge. The memory stays unwritten until the edge where `slot_now` equals the source index. That edge writes it, and `busy` is low afterwards.
- R8: Requests a core presents while its `busy` bit is high are ignored and write nothing.
- R9: A write into a memory from any other core sets that memory's `evt_flag`. The flag stays set until `evt_clr` is pulsed. When a set and a clear fall on the same edge, the set wins.
- R10: A core writing its own memory (its own mask bit) updates the memory but does not set its own `evt_flag`.
- R11: A request with an all-zero mask writes no memory and sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NCORE | Write request present, one bit per core |
| req_mode | input | NCORE | 0 immediate, 1 slot-gated, per core |
| req_mask | input | NCORE*NCORE | Per-core target mask; bit t of core s's slice selects memory t |
| req_addr | input | NCORE*AW | Per-core word address |
| req_data | input | NCORE*DW | Per-core write data |
| busy | output | NCORE | Core holds a slot-gated request awaiting its slot |
| slot_now | output | log2(NCORE) | Current value of the rotating slot counter |
| rd_addr | input | NCORE*AW | Per-core read address into its own memory |
| rd_data | output | NCORE*DW | Per-core asynchronous read data |
| evt_clr | input | NCORE | Clear the core's write-happened flag |
| evt_flag | output | NCORE | Sticky foreign-write flag per memory |

## Verification
The merge path is tried with a single writer, a broadcast mask, two writers on one target with disjoint address and data bits, and two writers on separate targets in the same cycle. Disjoint bits make an OR-merge differ visibly from arbitration or last-writer-wins. Separate targets show that no source leaks into another target. Slot gating is started several slots ahead of the source index. This exposes an early or late issue and a `busy` that drops at the wrong edge. An immediate request pushed in during the wait proves that a held port ignores new requests. Self-writes, zero masks and a clear colliding with a set separate the flag's set, hold and clear rules.

// File: rtl/wfab_pkg.sv
package wfab_pkg;
    typedef enum logic {
        GATE_IDLE = 1'b0,
        GATE_HOLD = 1'b1
    } gate_state_e;

    localparam logic MODE_FAST = 1'b0;
    localparam logic MODE_SAFE = 1'b1;
endpackage

// File: rtl/wfab_slot_gate.sv
module wfab_slot_gate
    import wfab_pkg::*;
#(
    parameter int NCORE = 16,
    parameter int AW    = 7,
    parameter int DW    = 32,
    parameter int IDX   = 0,
    localparam int SW   = $clog2(NCORE)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SW-1:0]    slot,
    input  logic             req_valid,
    input  logic             req_mode,
    input  logic [NCORE-1:0] req_mask,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_data,
    output logic             busy,
    output logic             iss_valid,
    output logic             iss_safe,
    output logic [NCORE-1:0] iss_mask,
    output logic [AW-1:0]    iss_addr,
    output logic [DW-1:0]    iss_data
);
    gate_state_e      state_q, state_d;
    logic [NCORE-1:0] hold_mask;
    logic [AW-1:0]    hold_addr;
    logic [DW-1:0]    hold_data;
    logic             my_slot;

    assign my_slot = (slot == SW'(IDX));

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= GATE_IDLE;
        else     state_q <= state_d;
    end

    // Captured request, loaded on the IDLE-to-HOLD transition
    always_ff @(posedge clk) begin
        if (rst) begin
            hold_mask <= '0;
            hold_addr <= '0;
            hold_data <= '0;
        end else if (state_q == GATE_IDLE && state_d == GATE_HOLD) begin
            hold_mask <= req_mask;
            hold_addr <= req_addr;
            hold_data <= req_data;
        end
    end

    // Next state and outputs
    always_comb begin
        state_d   = state_q;
        busy      = 1'b0;
        iss_valid = 1'b0;
        iss_safe  = 1'b0;
        iss_mask  = req_mask;
        iss_addr  = req_addr;
        iss_data  = req_data;
        unique case (state_q)
            GATE_IDLE: begin
                if (req_valid) begin
                    if (req_mode == MODE_FAST) begin
                        iss_valid = 1'b1;
                    end else if (my_slot) begin
                        iss_valid = 1'b1;
                        iss_safe  = 1'b1;
                    end else begin
                        state_d = GATE_HOLD;
                    end
                end
            end
            GATE_HOLD: begin
                busy     = 1'b1;
                iss_safe = 1'b1;
                iss_mask = hold_mask;
                iss_addr = hold_addr;
                iss_data = hold_data;
                if (my_slot) begin
                    iss_valid = 1'b1;
                    state_d   = GATE_IDLE;
                end
            end
            default: state_d = GATE_IDLE;
        endcase
    end
endmodule

// File: rtl/wfab_merge_net.sv
module wfab_merge_net #(
    parameter int NCORE = 16,
    parameter int AW    = 7,
    parameter int DW    = 32
) (
    input  logic [NCORE-1:0]       iss_valid,
    input  logic [NCORE*NCORE-1:0] iss_mask,
    input  logic [NCORE*AW-1:0]    iss_addr,
    input  logic [NCORE*DW-1:0]    iss_data,
    output logic [NCORE-1:0]       tgt_we,
    output logic [NCORE-1:0]       tgt_foreign,
    output logic [NCORE*AW-1:0]    tgt_addr,
    output logic [NCORE*DW-1:0]    tgt_data
);
    for (genvar t = 0; t < NCORE; t++) begin : g_tgt
        always_comb begin
            tgt_we[t]                = 1'b0;
            tgt_foreign[t]           = 1'b0;
            tgt_addr[t*AW +: AW]     = '0;
            tgt_data[t*DW +: DW]     = '0;
            for (int s = 0; s < NCORE; s++) begin
                if (iss_valid[s] && iss_mask[s*NCORE + t]) begin
                    tgt_we[t]            = 1'b1;
                    tgt_addr[t*AW +: AW] = tgt_addr[t*AW +: AW] | iss_addr[s*AW +: AW];
                    tgt_data[t*DW +: DW] = tgt_data[t*DW +: DW] | iss_data[s*DW +: DW];
                    if (s != t) tgt_foreign[t] = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/wfab_lut_bank.sv
module wfab_lut_bank #(
    parameter int AW    = 7,
    parameter int DW    = 32,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic          foreign,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    input  logic          evt_clr,
    output logic          evt_flag
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rd_data = mem[rd_addr];

    always_ff @(posedge clk) begin
        if (rst)          evt_flag <= 1'b0;
        else if (foreign) evt_flag <= 1'b1;
        else if (evt_clr) evt_flag <= 1'b0;
    end
endmodule

// File: rtl/wfab_top.sv
module wfab_top #(
    parameter int NCORE = 16,
    parameter int AW    = 7,
    parameter int DW    = 32,
    localparam int SW   = $clog2(NCORE)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NCORE-1:0]       req_valid,
    input  logic [NCORE-1:0]       req_mode,
    input  logic [NCORE*NCORE-1:0] req_mask,
    input  logic [NCORE*AW-1:0]    req_addr,
    input  logic [NCORE*DW-1:0]    req_data,
    output logic [NCORE-1:0]       busy,
    output logic [SW-1:0]          slot_now,
    input  logic [NCORE*AW-1:0]    rd_addr,
    output logic [NCORE*DW-1:0]    rd_data,
    input  logic [NCORE-1:0]       evt_clr,
    output logic [NCORE-1:0]       evt_flag
);
    logic [SW-1:0]          slot_q;
    logic [NCORE-1:0]       iss_valid;
    logic [NCORE-1:0]       iss_safe;
    logic [NCORE*NCORE-1:0] iss_mask;
    logic [NCORE*AW-1:0]    iss_addr;
    logic [NCORE*DW-1:0]    iss_data;
    logic [NCORE-1:0]       tgt_we;
    logic [NCORE-1:0]       tgt_foreign;
    logic [NCORE*AW-1:0]    tgt_addr;
    logic [NCORE*DW-1:0]    tgt_data;

    // Rotating slot counter; NCORE is a power of two so it wraps naturally
    always_ff @(posedge clk) begin
        if (rst) slot_q <= '0;
        else     slot_q <= slot_q + 1'b1;
    end
    assign slot_now = slot_q;

    for (genvar c = 0; c < NCORE; c++) begin : g_core
        wfab_slot_gate #(.NCORE(NCORE), .AW(AW), .DW(DW), .IDX(c)) u_gate (
            .clk       (clk),
            .rst       (rst),
            .slot      (slot_q),
            .req_valid (req_valid[c]),
            .req_mode  (req_mode[c]),
            .req_mask  (req_mask[c*NCORE +: NCORE]),
            .req_addr  (req_addr[c*AW +: AW]),
            .req_data  (req_data[c*DW +: DW]),
            .busy      (busy[c]),
            .iss_valid (iss_valid[c]),
            .iss_safe  (iss_safe[c]),
            .iss_mask  (iss_mask[c*NCORE +: NCORE]),
            .iss_addr  (iss_addr[c*AW +: AW]),
            .iss_data  (iss_data[c*DW +: DW])
        );

        wfab_lut_bank #(.AW(AW), .DW(DW)) u_bank (
            .clk      (clk),
            .rst      (rst),
            .we       (tgt_we[c]),
            .foreign  (tgt_foreign[c]),
            .waddr    (tgt_addr[c*AW +: AW]),
            .wdata    (tgt_data[c*DW +: DW]),
            .rd_addr  (rd_addr[c*AW +: AW]),
            .rd_data  (rd_data[c*DW +: DW]),
            .evt_clr  (evt_clr[c]),
            .evt_flag (evt_flag[c])
        );
    end

    wfab_merge_net #(.NCORE(NCORE), .AW(AW), .DW(DW)) u_merge (
        .iss_valid   (iss_valid),
        .iss_mask    (iss_mask),
        .iss_addr    (iss_addr),
        .iss_data    (iss_data),
        .tgt_we      (tgt_we),
        .tgt_foreign (tgt_foreign),
        .tgt_addr    (tgt_addr),
        .tgt_data    (tgt_data)
    );
endmodule

// File: rtl/wfab_checker.sv
module wfab_checker #(
    parameter int NCORE = 16,
    localparam int SW   = $clog2(NCORE)
) (
    input logic             clk,
    input logic             rst,
    input logic [SW-1:0]    slot,
    input logic [NCORE-1:0] busy,
    input logic [NCORE-1:0] req_valid,
    input logic [NCORE-1:0] req_mode,
    input logic [NCORE-1:0] iss_valid,
    input logic [NCORE-1:0] iss_safe,
    input logic [NCORE-1:0] evt_flag,
    input logic [NCORE-1:0] evt_clr
);
    AST_SLOT_STEP: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (slot == SW'($past(slot) + 1'b1))); // R2

    for (genvar i = 0; i < NCORE; i++) begin : g_src
        AST_SAFE_IN_SLOT: assert property (@(posedge clk) disable iff (rst)
            (iss_valid[i] && iss_safe[i]) |-> (slot == SW'(i))); // R7

        AST_BUSY_FROM_SAFE: assert property (@(posedge clk) disable iff (rst)
            $rose(busy[i]) |-> $past(req_valid[i] && req_mode[i])); // R7

        AST_BUSY_NO_ISSUE: assert property (@(posedge clk) disable iff (rst)
            (busy[i] && slot != SW'(i)) |-> !iss_valid[i]); // R8

        AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
            (evt_flag[i] && !evt_clr[i]) |=> evt_flag[i]); // R9
    end
endmodule

bind wfab_top wfab_checker #(.NCORE(NCORE)) u_wfab_checker (
    .clk       (clk),
    .rst       (rst),
    .slot      (slot_q),
    .busy      (busy),
    .req_valid (req_valid),
    .req_mode  (req_mode),
    .iss_valid (iss_valid),
    .iss_safe  (iss_safe),
    .evt_flag  (evt_flag),
    .evt_clr   (evt_clr)
);

// File: tb/test_wfab_top.sv
`timescale 1ns/1ps
module test_wfab_top;
    localparam int N  = 16;
    localparam int AW = 7;
    localparam int DW = 32;
    localparam int SW = 4;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [N-1:0]       req_valid = '0;
    logic [N-1:0]       req_mode  = '0;
    logic [N*N-1:0]     req_mask  = '0;
    logic [N*AW-1:0]    req_addr  = '0;
    logic [N*DW-1:0]    req_data  = '0;
    logic [N-1:0]       busy;
    logic [SW-1:0]      slot_now;
    logic [N*AW-1:0]    rd_addr   = '0;
    logic [N*DW-1:0]    rd_data;
    logic [N-1:0]       evt_clr   = '0;
    logic [N-1:0]       evt_flag;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done   = 0;

    always #4 clk = ~clk; // 125 MHz

    wfab_top #(.NCORE(N), .AW(AW), .DW(DW)) i_wfab_top (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_mode(req_mode),
        .req_mask(req_mask), .req_addr(req_addr), .req_data(req_data),
        .busy(busy), .slot_now(slot_now), .rd_addr(rd_addr), .rd_data(rd_data),
        .evt_clr(evt_clr), .evt_flag(evt_flag)
    );

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic put(input int s, input logic mode, input logic [N-1:0] mask,
                       input int a, input logic [DW-1:0] d);
        req_valid[s]          = 1'b1;
        req_mode[s]           = mode;
        req_mask[s*N +: N]    = mask;
        req_addr[s*AW +: AW]  = AW'(a);
        req_data[s*DW +: DW]  = d;
    endtask

    task automatic drop_all();
        req_valid = '0;
        req_mode  = '0;
        req_mask  = '0;
        req_addr  = '0;
        req_data  = '0;
    endtask

    task automatic rd(input int t, input int a, output logic [DW-1:0] d);
        rd_addr[t*AW +: AW] = AW'(a);
        #1;
        d = rd_data[t*DW +: DW];
    endtask

    task automatic fast_wr(input int s, input logic [N-1:0] mask, input int a, input logic [DW-1:0] d);
        put(s, 1'b0, mask, a, d);
        step();
        drop_all();
    endtask

    task automatic clr_flags();
        evt_clr = '1;
        step();
        evt_clr = '0;
    endtask

    task automatic wait_slot(input int s);
        while (slot_now != SW'(s)) step();
    endtask

    task automatic t_reset();
        check("R1 flags", 32'(evt_flag), 32'h0);
        check("R1 busy", 32'(busy), 32'h0);
        check("R1 slot", 32'(slot_now), 32'h0);
    endtask

    task automatic t_slot();
        int errs = 0;
        for (int k = 0; k < 20; k++) begin
            logic [SW-1:0] s = slot_now;
            step();
            if (slot_now != SW'(s + 1'b1)) errs++;
        end
        check("R2 slot step errors", 32'(errs), 32'h0);
    endtask

    task automatic t_fast_single();
        logic [DW-1:0] d;
        clr_flags();
        fast_wr(0, 16'h0002, 3, 32'h1111_1111);
        rd(1, 3, d);
        check("R3 fast write", d, 32'h1111_1111);
        check("R9 flag set", 32'(evt_flag), 32'h0002);
    endtask

    task automatic t_broadcast();
        logic [DW-1:0] d;
        clr_flags();
        fast_wr(2, 16'hF0F0, 8, 32'h0000_CAFE);
        for (int t = 0; t < N; t++) begin
            if (t[3:0] inside {4,5,6,7,12,13,14,15}) begin
                rd(t, 8, d);
                check($sformatf("R4 broadcast target %0d", t), d, 32'h0000_CAFE);
            end
        end
        check("R4 broadcast flags", 32'(evt_flag), 32'h0000_F0F0);
    endtask

    task automatic t_merge();
        logic [DW-1:0] d;
        fast_wr(0, 16'h0080, 7'h0F, 32'h0);
        fast_wr(0, 16'h0080, 7'h05, 32'hAAAA_AAAA);
        fast_wr(0, 16'h0080, 7'h0A, 32'h5555_5555);
        put(1, 1'b0, 16'h0080, 7'h05, 32'h0000_00F0);
        put(2, 1'b0, 16'h0080, 7'h0A, 32'h0000_000F);
        step();
        drop_all();
        rd(7, 7'h0F, d);
        check("R5 merged addr/data", d, 32'h0000_00FF);
        rd(7, 7'h05, d);
        check("R5 no separate write a", d, 32'hAAAA_AAAA);
        rd(7, 7'h0A, d);
        check("R5 no separate write b", d, 32'h5555_5555);
    endtask

    task automatic t_indep();
        logic [DW-1:0] d;
        put(1, 1'b0, 16'h0010, 2, 32'hA0A0_0001);
        put(2, 1'b0, 16'h0020, 9, 32'h0B0B_0002);
        step();
        drop_all();
        rd(4, 2, d);
        check("R6 target 4", d, 32'hA0A0_0001);
        rd(5, 9, d);
        check("R6 target 5", d, 32'h0B0B_0002);
    endtask

    task automatic t_safe();
        logic [DW-1:0] d;
        int waited = 0;
        fast_wr(0, 16'h0200, 7'h20, 32'h0);
        clr_flags();
        wait_slot(5);
        put(3, 1'b1, 16'h0200, 7'h20, 32'h0000_3333);
        step();
        drop_all();
        check("R7 busy after capture", 32'(busy), 32'h0008);
        rd(9, 7'h20, d);
        check("R7 not yet written", d, 32'h0);
        while (busy[3] && waited < 40) begin
            step();
            waited++;
        end
        check("R7 busy clears after slot 3", 32'(slot_now), 32'd4);
        rd(9, 7'h20, d);
        check("R7 written in slot", d, 32'h0000_3333);
        check("R7 flag from gated write", 32'(evt_flag), 32'h0200);
    endtask

    task automatic t_busy_ignore();
        logic [DW-1:0] d;
        int waited = 0;
        fast_wr(0, 16'h0400, 7'h21, 32'h0);
        clr_flags();
        wait_slot(6);
        put(3, 1'b1, 16'h0200, 7'h22, 32'h0000_4444);
        step();
        drop_all();
        put(3, 1'b0, 16'h0400, 7'h21, 32'hDEAD_BEEF);
        step();
        drop_all();
        while (busy[3] && waited < 40) begin
            step();
            waited++;
        end
        rd(10, 7'h21, d);
        check("R8 request during busy ignored", d, 32'h0);
        check("R8 no flag on ignored target", 32'(evt_flag[10]), 32'h0);
        rd(9, 7'h22, d);
        check("R8 held request still lands", d, 32'h0000_4444);
    endtask

    task automatic t_sticky();
        clr_flags();
        fast_wr(0, 16'h0800, 1, 32'h1);
        step(); step(); step();
        check("R9 flag sticky", 32'(evt_flag), 32'h0800);
        clr_flags();
        check("R9 flag cleared", 32'(evt_flag), 32'h0);
        put(0, 1'b0, 16'h0800, 1, 32'h2);
        evt_clr = '1;
        step();
        drop_all();
        evt_clr = '0;
        check("R9 set beats clear", 32'(evt_flag), 32'h0800);
    endtask

    task automatic t_self();
        logic [DW-1:0] d;
        clr_flags();
        fast_wr(6, 16'h0040, 7'h11, 32'h6666_0000);
        rd(6, 7'h11, d);
        check("R10 self write lands", d, 32'h6666_0000);
        check("R10 self write no flag", 32'(evt_flag), 32'h0);
    endtask

    task automatic t_zero();
        logic [DW-1:0] d;
        fast_wr(0, 16'h0001, 7'h30, 32'h7777_7777);
        clr_flags();
        put(5, 1'b0, 16'h0000, 7'h30, 32'h0);
        step();
        drop_all();
        check("R11 zero mask no flag", 32'(evt_flag), 32'h0);
        rd(0, 7'h30, d);
        check("R11 zero mask no write", d, 32'h7777_7777);
    endtask

    initial begin
        step(); step();
        rst = 1'b0;
        t_reset();
        t_slot();
        t_fast_single();
        t_broadcast();
        t_merge();
        t_indep();
        t_safe();
        t_busy_ignore();
        t_sticky();
        t_self();
        t_zero();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule